// File: doc/BRIEF.md
# Synthesizer Serial Word Loader

This block writes configuration words into a frequency synthesizer over a three-wire link: a serial data line, a serial clock and a load-enable strobe. A host presents a right-aligned word and its bit count. The block clocks the word out most significant bit first, then raises load enable for one serial-clock period. That pulse makes the synthesizer latch the word into the counter register named by the word's two trailing control bits.

A small sequencer handles power-up. On a start pulse it writes three fixed counter words, one after another: first the IF reference counter, then the IF divide counter, and last the RF reference counter. It raises a done flag once the last of the three words has been latched. The serial clock is the system clock divided by a parameter. It idles low.

Top module: `synth_word_loader`

## Requirements
- R1: After reset, serial clock, serial data, load enable, busy and done are all low.
- R2: An accepted host word of length L (1 to 22) produces exactly L rising serial-clock edges. At each edge the data line carries word bit L-1 first, then the lower bits in turn down to bit 0.
- R3: Serial data changes only while the serial clock is low. Each high phase of the serial clock lasts DIV system-clock cycles, and each low phase also lasts DIV cycles.
- R4: Load enable stays low while bits are shifting. After the last bit it is high for exactly 2*DIV system-clock cycles, and the serial clock stays low during that time.
- R5: The serial clock is low whenever the block is not busy.
- R6: Busy rises on the cycle after a word is accepted and falls when load enable falls. Host requests made while busy produce no serial activity and no extra load pulse.
- R7: A host request with length 0 or length above 22 is ignored. Busy stays low and no load pulse is produced.
- R8: A start pulse on init_start writes three 22-bit words in this order. Each word carries the preset counter value in bits 21:2 and a control code in bits 1:0. The order and codes are: IF reference (code 00), IF divide (code 01), RF reference (code 10).
- R9: Done rises on the same clock edge on which the third load pulse ends, and never while a load pulse is high. A new start pulse clears done on the next cycle.
- R10: If init_start and a host request arrive in the same cycle, the initialisation list runs and the host word is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request strobe, one cycle |
| req_word | input | 22 | Host word, right-aligned |
| req_len | input | 5 | Number of bits to send |
| init_start | input | 1 | Starts the power-up list |
| busy | output | 1 | Transfer or list in progress |
| init_done | output | 1 | Power-up list finished |
| syn_data | output | 1 | Serial data to the synthesizer |
| syn_clk | output | 1 | Serial clock to the synthesizer |
| syn_le | output | 1 | Load enable to the synthesizer |

## Verification
Two pairs of functions can fall in the same cycle. The first is a host request arriving together with a start pulse. The bench drives both on one edge and checks that exactly three load pulses follow, that they carry the list words in order, and that the host word never appears. The second is the end of the last load pulse coinciding with the rise of done. The bench records done while load enable is high and again on the cycle after it falls; the checker also requires done to rise only on the cycle in which load enable falls.

// File: rtl/synl_pkg.sv
package synl_pkg;

    localparam int CTL_W  = 2;
    localparam int CNT_W  = 20;
    localparam int WORD_W = CNT_W + CTL_W;
    localparam int LEN_W  = $clog2(WORD_W + 1);
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int LIST_LEN = 3;
    localparam int LIST_W   = $clog2(LIST_LEN);

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_BITS,
        SH_LOAD
    } sh_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT
    } sq_state_e;

    typedef enum logic [CTL_W-1:0] {
        TGT_IF_R = 2'b00,
        TGT_IF_N = 2'b01,
        TGT_RF_R = 2'b10,
        TGT_RF_N = 2'b11
    } tgt_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [LEN_W-1:0]  len;
    } xfer_t;

    function automatic logic [WORD_W-1:0] pack_word(logic [CNT_W-1:0] val, tgt_e tgt);
        return {val, tgt};
    endfunction

    function automatic tgt_e list_target(logic [LIST_W-1:0] idx);
        case (idx)
            2'd0:    return TGT_IF_R;
            2'd1:    return TGT_IF_N;
            default: return TGT_RF_R;
        endcase
    endfunction

    function automatic logic len_ok(logic [LEN_W-1:0] len);
        return (len != '0) && (int'(len) <= WORD_W);
    endfunction

endpackage

// File: rtl/synl_baud.sv
module synl_baud #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic ph_hi,
    output logic ph_end
);
    localparam int PER   = 2 * DIV;
    localparam int CNT_W = $clog2(PER);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (ph_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ph_hi  = int'(cnt_q) >= DIV;
    assign ph_end = int'(cnt_q) == PER - 1;
endmodule

// File: rtl/synl_shift.sv
module synl_shift
    import synl_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  go,
    input  xfer_t xfer,
    output logic  busy,
    output logic  finish,
    output logic  sdata,
    output logic  sclk,
    output logic  le
);
    sh_state_e          st_q;
    logic [WORD_W-1:0]  word_q;
    logic [IDX_W-1:0]   bit_q;
    logic               ph_hi, ph_end;

    synl_baud #(.DIV(DIV)) u_baud (
        .clk   (clk),
        .rst   (rst),
        .run   (st_q != SH_IDLE),
        .ph_hi (ph_hi),
        .ph_end(ph_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SH_IDLE;
            word_q <= '0;
            bit_q  <= '0;
        end else begin
            case (st_q)
                SH_IDLE: if (go) begin
                    word_q <= xfer.word;
                    bit_q  <= IDX_W'(xfer.len - 1'b1);
                    st_q   <= SH_BITS;
                end
                SH_BITS: if (ph_end) begin
                    if (bit_q == '0) st_q <= SH_LOAD;
                    else             bit_q <= bit_q - 1'b1;
                end
                SH_LOAD: if (ph_end) st_q <= SH_IDLE;
                default: st_q <= SH_IDLE;
            endcase
        end
    end

    assign busy   = st_q != SH_IDLE;
    assign finish = (st_q == SH_LOAD) && ph_end;
    assign sclk   = (st_q == SH_BITS) && ph_hi;
    assign sdata  = (st_q == SH_BITS) && word_q[bit_q];
    assign le     = st_q == SH_LOAD;
endmodule

// File: rtl/synl_seq.sv
module synl_seq
    import synl_pkg::*;
#(
    parameter logic [CNT_W-1:0] IF_R_VAL = 20'h00A03,
    parameter logic [CNT_W-1:0] IF_N_VAL = 20'h04B2C,
    parameter logic [CNT_W-1:0] RF_R_VAL = 20'h00C05
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  finish,
    output logic  running,
    output logic  go,
    output xfer_t xfer,
    output logic  done
);
    sq_state_e          st_q;
    logic [LIST_W-1:0]  idx_q;
    logic [CNT_W-1:0]   vals [LIST_LEN];

    assign vals[0] = IF_R_VAL;
    assign vals[1] = IF_N_VAL;
    assign vals[2] = RF_R_VAL;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SQ_IDLE;
            idx_q <= '0;
            done  <= 1'b0;
        end else begin
            case (st_q)
                SQ_IDLE: if (start) begin
                    idx_q <= '0;
                    done  <= 1'b0;
                    st_q  <= SQ_ISSUE;
                end
                SQ_ISSUE: st_q <= SQ_WAIT;
                SQ_WAIT: if (finish) begin
                    if (int'(idx_q) == LIST_LEN - 1) begin
                        done <= 1'b1;
                        st_q <= SQ_IDLE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                        st_q  <= SQ_ISSUE;
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    assign running   = st_q != SQ_IDLE;
    assign go        = st_q == SQ_ISSUE;
    assign xfer.word = pack_word(vals[idx_q], list_target(idx_q));
    assign xfer.len  = LEN_W'(WORD_W);
endmodule

// File: rtl/synth_word_loader.sv
module synth_word_loader
    import synl_pkg::*;
#(
    parameter int DIV = 4,
    parameter logic [CNT_W-1:0] IF_R_VAL = 20'h00A03,
    parameter logic [CNT_W-1:0] IF_N_VAL = 20'h04B2C,
    parameter logic [CNT_W-1:0] RF_R_VAL = 20'h00C05
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [WORD_W-1:0] req_word,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              init_start,
    output logic              busy,
    output logic              init_done,
    output logic              syn_data,
    output logic              syn_clk,
    output logic              syn_le
);
    logic  sh_busy, sh_finish, sh_go;
    logic  sq_running, sq_go, sq_start, host_go;
    xfer_t sq_xfer, host_xfer, sh_xfer;

    assign busy      = sh_busy | sq_running;
    assign sq_start  = init_start & ~busy;
    assign host_go   = req_valid & ~busy & ~init_start & len_ok(req_len);
    assign host_xfer = '{word: req_word, len: req_len};
    assign sh_go     = sq_go | host_go;
    assign sh_xfer   = sq_go ? sq_xfer : host_xfer;

    synl_seq #(
        .IF_R_VAL(IF_R_VAL),
        .IF_N_VAL(IF_N_VAL),
        .RF_R_VAL(RF_R_VAL)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (sq_start),
        .finish (sh_finish),
        .running(sq_running),
        .go     (sq_go),
        .xfer   (sq_xfer),
        .done   (init_done)
    );

    synl_shift #(.DIV(DIV)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .go    (sh_go),
        .xfer  (sh_xfer),
        .busy  (sh_busy),
        .finish(sh_finish),
        .sdata (syn_data),
        .sclk  (syn_clk),
        .le    (syn_le)
    );
endmodule

// File: rtl/synl_chk.sv
module synl_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic sdata,
    input logic sclk,
    input logic le
);
    // R3
    sdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(sdata));

    // R4
    le_sclk_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(le && sclk));

    // R5
    idle_clk_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk);

    // R6
    le_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        le |-> busy);

    // R9
    done_on_le_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $fell(le));

    // R9
    done_not_during_le_chk: assert property (@(posedge clk) disable iff (rst)
        le |-> !$rose(done));
endmodule

bind synth_word_loader synl_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .busy (busy),
    .done (init_done),
    .sdata(syn_data),
    .sclk (syn_clk),
    .le   (syn_le)
);

// File: tb/sim_synth_word_loader.sv
`timescale 1ns/1ps
module sim_synth_word_loader;
    localparam int DIV = 2;
    localparam int WW  = 22;
    localparam logic [19:0] VR1 = 20'h00A03;
    localparam logic [19:0] VN1 = 20'h04B2C;
    localparam logic [19:0] VR2 = 20'h00C05;

    logic clk = 0, rst = 1;
    logic req_valid = 0, init_start = 0;
    logic [21:0] req_word = '0;
    logic [4:0]  req_len = '0;
    logic busy, init_done, syn_data, syn_clk, syn_le;

    int vec = 0, bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    synth_word_loader #(
        .DIV(DIV), .IF_R_VAL(VR1), .IF_N_VAL(VN1), .RF_R_VAL(VR2)
    ) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_word(req_word),
        .req_len(req_len), .init_start(init_start), .busy(busy),
        .init_done(init_done), .syn_data(syn_data), .syn_clk(syn_clk),
        .syn_le(syn_le)
    );

    // protocol monitor
    logic [31:0] cap = '0;
    int ncap = 0, nlat = 0;
    logic [31:0] lat_w [0:15];
    int lat_n [0:15];
    int sclk_bad = 0, le_bad = 0, sclk_in_le = 0, done_in_le = 0;
    time t_hi = 0, t_le = 0;

    always @(posedge syn_clk) begin
        cap = {cap[30:0], syn_data};
        ncap++;
        t_hi = $time;
        if (syn_le) sclk_in_le++;
    end
    always @(negedge syn_clk) if ((($time - t_hi) / 8) != DIV) sclk_bad++;
    always @(posedge syn_le) begin
        lat_w[nlat % 16] = cap;
        lat_n[nlat % 16] = ncap;
        nlat++;
        cap = '0;
        ncap = 0;
        t_le = $time;
    end
    always @(negedge syn_le) if ((($time - t_le) / 8) != 2 * DIV) le_bad++;
    always @(negedge clk) if (syn_le && init_done) done_in_le++;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [21:0] w, input logic [4:0] l);
        @(negedge clk);
        req_valid = 1; req_word = w; req_len = l;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; vec++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({syn_clk, syn_data, syn_le, busy, init_done} == 5'b0, "R1 reset outputs",
            {syn_clk, syn_data, syn_le, busy, init_done}, 0);
        rst = 0;
        @(negedge clk);
        // R5 idle clock
        chk(!syn_clk, "R5 idle sclk", syn_clk, 0);

        // R2 sweep over all lengths and two patterns
        for (int l = 1; l <= WW; l++) begin
            for (int p = 0; p < 2; p++) begin
                logic [21:0] w;
                logic [31:0] expw;
                int base;
                w = (p == 0) ? (22'h2AAAAA ^ 22'(l * 37)) : (22'h15C3A5 + 22'(l * 1013));
                expw = 32'(w) & ((32'd1 << l) - 1);
                base = nlat;
                send(w, 5'(l));
                // R6 busy right after accept
                if (l == 1 && p == 0) chk(busy, "R6 busy after accept", busy, 1);
                wait_idle();
                chk(nlat == base + 1 && lat_w[base % 16] == expw && lat_n[base % 16] == l,
                    "R2 word bits", lat_w[base % 16], expw);
            end
        end
        // R3 R4 timing over the whole sweep
        chk(sclk_bad == 0, "R3 sclk high width", sclk_bad, 0);
        chk(le_bad == 0, "R4 le width", le_bad, 0);
        chk(sclk_in_le == 0, "R4 sclk during le", sclk_in_le, 0);
        chk(!syn_clk, "R5 sclk low after sweep", syn_clk, 0);

        // R6 request while busy ignored
        begin
            int base;
            base = nlat;
            send(22'h3F0F0F, 5'd22);
            repeat (3) @(negedge clk);
            send(22'h000123, 5'd12);
            wait_idle();
            repeat (10) @(negedge clk);
            chk(nlat == base + 1, "R6 one latch only", nlat - base, 1);
            chk(lat_w[base % 16] == 32'h3F0F0F, "R6 first word kept", lat_w[base % 16], 32'h3F0F0F);
        end

        // R7 invalid lengths
        begin
            int base;
            base = nlat;
            send(22'h1, 5'd0);
            chk(!busy, "R7 len 0 not busy", busy, 0);
            send(22'h1, 5'd23);
            chk(!busy, "R7 len 23 not busy", busy, 0);
            repeat (20) @(negedge clk);
            chk(nlat == base, "R7 no latch", nlat - base, 0);
        end

        // R10 init and host request in same cycle; R8 order
        begin
            int base;
            logic [31:0] e0, e1, e2;
            base = nlat;
            e0 = {10'b0, VR1, 2'b00};
            e1 = {10'b0, VN1, 2'b01};
            e2 = {10'b0, VR2, 2'b10};
            @(negedge clk);
            init_start = 1; req_valid = 1; req_word = 22'h2BEEF1; req_len = 5'd22;
            @(negedge clk);
            init_start = 0; req_valid = 0;
            while (!init_done) @(negedge clk);
            repeat (10) @(negedge clk);
            chk(nlat == base + 3, "R10 three latches only", nlat - base, 3);
            chk(lat_w[base % 16] == e0 && lat_n[base % 16] == 22, "R8 IF R first", lat_w[base % 16], e0);
            chk(lat_w[(base + 1) % 16] == e1, "R8 IF N second", lat_w[(base + 1) % 16], e1);
            chk(lat_w[(base + 2) % 16] == e2, "R8 RF R third", lat_w[(base + 2) % 16], e2);
            chk(done_in_le == 0, "R9 done not during le", done_in_le, 0);
        end

        // R9 done cleared by new start, set again at end
        @(negedge clk);
        init_start = 1;
        @(negedge clk);
        init_start = 0;
        chk(!init_done, "R9 done cleared", init_done, 0);
        while (!syn_le) @(negedge clk);
        while (syn_le || busy) begin
            if (!busy) break;
            @(negedge clk);
        end
        wait_idle();
        chk(init_done, "R9 done set", init_done, 1);
        chk(done_in_le == 0, "R9 done timing", done_in_le, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule